// File: doc/BRIEF.md
# Voltage Regulator Startup Sequencer

This block is the digital sequencer of a multiphase CPU core regulator. At the rising edge of the enable input it latches four things: which control interface is in use (parallel or serial), the boot voltage code, the active phase count taken from two strap pins, and the power-save strategy pin. It then raises a 6-bit target code from zero toward the boot code at a slow soft-start pace. When the target reaches the boot code it asserts power-good. From then on it follows requested codes at a faster slew pace.

In parallel mode the live six-bit VID bus is the request, and the northbridge rail is held off in high impedance. In serial mode the boot level comes from the two serial lines. The serial clock and data lines are passed out raw for a command decoder outside this block. Power-good drops only when enable is removed or when a fault occurs, and a fault keeps every phase off until enable is cycled. The target code counts in 25 mV steps, so code 44 stands for 1.1 V.

Top module: `vr_boot_seq`

## Requirements
- R1: At the enable rising edge, `vid_i[1]`=1 selects parallel mode and `vid_i[1]`=0 selects serial mode. `par_mode_o` shows the latched mode until the next enable edge.
- R2: In parallel mode the boot code is `vid_i[5:0]` at the enable edge, with bit 5 as the MSB. After power-good the request is the live `vid_i`. `nb_hiz_o`=1 and `nb_en_o`=0 at all times, and `pwrok_i` has no effect.
- R3: In serial mode the boot code is set by {`vid_i[2]`,`vid_i[3]`} at the enable edge: 00→44, 01→40, 10→36, 11→32. After the edge, `vid_i[0]`, `vid_i[1]`, `vid_i[4]` and `vid_i[5]` have no effect. `sv_clk_o`=`vid_i[2]`, `sv_dat_o`=`vid_i[3]`, `nb_hiz_o`=0, and `nb_en_o`=`pgood_o` AND `pwrok_i`.
- R4: Soft-start begins at code 0 and steps +1 only once per SS_DIV cycles. `pgood_o` rises in the cycle where the code equals the boot code, and later requests are ignored until then.
- R5: After power-good, the code moves by at most one step per SLEW_DIV cycles, up or down, until it equals the request. `pgood_o` stays high while enable is high and there is no fault.
- R6: The phase straps are latched at the enable edge and ignored afterwards. G4=1 gives `phase_en_o`=4'b1111. G4=0 with G2=1 gives 4'b0111. G4=0 with G2=0 gives 4'b0011. Phases are enabled only during soft-start and regulation.
- R7: `psi_n_i` is latched at the enable edge. `psave_o` is 1 only while regulating (after soft-start) if the latched value was 0.
- R8: One clock after `en_i` is sampled low: `code_o`=0, `pgood_o`=0, `phase_en_o`=0, `psave_o`=0.
- R9: With `en_i` high, `fault_i`=1 gives `pgood_o`=0 and `phase_en_o`=0 one clock later. This holds after the fault clears, until `en_i` falls and rises again.
- R10: After reset: `code_o`=0, `pgood_o`=0, `phase_en_o`=0, `psave_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Regulator enable (turn-on command) |
| vid_i | input | 6 | Parallel VID bus; bits 2 and 3 are the serial clock and data lines |
| psi_n_i | input | 1 | Power-save strategy pin, active low |
| strap_g4_i | input | 1 | Phase strap, 0 drops the fourth phase |
| strap_g2_i | input | 1 | Phase strap, 0 with G4=0 leaves two phases |
| pwrok_i | input | 1 | Platform power-ok, used in serial mode only |
| fault_i | input | 1 | Fault indication |
| code_o | output | 6 | Target voltage code |
| nb_en_o | output | 1 | Northbridge rail enable |
| nb_hiz_o | output | 1 | Northbridge output high impedance |
| phase_en_o | output | 4 | Per-phase enables |
| pgood_o | output | 1 | Power-good |
| psave_o | output | 1 | Power-save engaged |
| par_mode_o | output | 1 | Latched mode, 1 = parallel |
| sv_clk_o | output | 1 | Raw serial clock pass-through |
| sv_dat_o | output | 1 | Raw serial data pass-through |

## Verification
Some properties are checked on every cycle. The code never moves by more than one step per clock, and during soft-start it moves only on a pacing tick. Power-good never drops while enable is held and no fault is present. Disabling or a fault clears the outputs one clock later, and the northbridge is held off in parallel mode. Other behaviour can only be shown by the bench's scenarios: the boot code chosen for each mode and strap setting, the phase masks, the serial lines being ignored, the delay before power-save takes effect, and the code following later requests in both directions.

// File: rtl/vr_boot_pkg.sv
package vr_boot_pkg;
  localparam int CODE_W = 6;
  localparam int PH_N   = 4;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_SS    = 2'd1,
    ST_REG   = 2'd2,
    ST_FAULT = 2'd3
  } seq_state_e;

  function automatic logic [CODE_W-1:0] step_toward(
    input logic [CODE_W-1:0] cur, input logic [CODE_W-1:0] req);
    if (cur < req)      return cur + 1'b1;
    else if (cur > req) return cur - 1'b1;
    else                return cur;
  endfunction

  // 25 mV per code: 44 = 1.1 V, each serial level 4 codes lower
  function automatic logic [CODE_W-1:0] serial_boot(input logic sclk, input logic sdat);
    return CODE_W'(44) - CODE_W'({sclk, sdat, 2'b00});
  endfunction

  function automatic logic [PH_N-1:0] phase_mask(input logic g4, input logic g2);
    if (g4)      return 4'b1111;
    else if (g2) return 4'b0111;
    else         return 4'b0011;
  endfunction
endpackage

// File: rtl/vr_rate_tick.sv
module vr_rate_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vr_mode_latch.sv
module vr_mode_latch
  import vr_boot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [CODE_W-1:0] vid,
  input  logic              psi_n,
  input  logic              g4,
  input  logic              g2,
  output logic              par,
  output logic [CODE_W-1:0] boot,
  output logic              psi_lat_n,
  output logic [PH_N-1:0]   mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par       <= 1'b0;
      boot      <= '0;
      psi_lat_n <= 1'b1;
      mask      <= '0;
    end else if (cap) begin
      par       <= vid[1];
      boot      <= vid[1] ? vid : serial_boot(vid[2], vid[3]);
      psi_lat_n <= psi_n;
      mask      <= phase_mask(g4, g2);
    end
  end
endmodule

// File: rtl/vr_boot_seq.sv
module vr_boot_seq
  import vr_boot_pkg::*;
#(
  parameter int SS_DIV   = 8,
  parameter int SLEW_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CODE_W-1:0] vid_i,
  input  logic              psi_n_i,
  input  logic              strap_g4_i,
  input  logic              strap_g2_i,
  input  logic              pwrok_i,
  input  logic              fault_i,
  output logic [CODE_W-1:0] code_o,
  output logic              nb_en_o,
  output logic              nb_hiz_o,
  output logic [PH_N-1:0]   phase_en_o,
  output logic              pgood_o,
  output logic              psave_o,
  output logic              par_mode_o,
  output logic              sv_clk_o,
  output logic              sv_dat_o
);
  seq_state_e        state;
  logic              en_q;
  logic              en_rise;
  logic              in_ss, in_reg;
  logic              ss_tick, slew_tick;
  logic              par;
  logic [CODE_W-1:0] boot, req;
  logic              psi_lat_n;
  logic [PH_N-1:0]   mask;

  assign en_rise = en_i && !en_q && (state == ST_OFF);
  assign in_ss   = (state == ST_SS);
  assign in_reg  = (state == ST_REG);
  assign req     = par ? vid_i : boot;

  vr_mode_latch u_latch (
    .clk(clk), .rst_n(rst_n), .cap(en_rise), .vid(vid_i), .psi_n(psi_n_i),
    .g4(strap_g4_i), .g2(strap_g2_i),
    .par(par), .boot(boot), .psi_lat_n(psi_lat_n), .mask(mask)
  );

  vr_rate_tick #(.DIV(SS_DIV))   u_ss_tick   (.clk(clk), .rst_n(rst_n), .run(in_ss),  .tick(ss_tick));
  vr_rate_tick #(.DIV(SLEW_DIV)) u_slew_tick (.clk(clk), .rst_n(rst_n), .run(in_reg), .tick(slew_tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_OFF;
      code_o  <= '0;
      pgood_o <= 1'b0;
    end else if (!en_i) begin
      state   <= ST_OFF;
      code_o  <= '0;
      pgood_o <= 1'b0;
    end else begin
      unique case (state)
        ST_OFF: begin
          code_o  <= '0;
          pgood_o <= 1'b0;
          if (en_rise) state <= fault_i ? ST_FAULT : ST_SS;
        end
        ST_SS: begin
          if (fault_i) begin
            state <= ST_FAULT;
          end else if (code_o == boot) begin
            state   <= ST_REG;
            pgood_o <= 1'b1;
          end else if (ss_tick) begin
            code_o <= step_toward(code_o, boot);
          end
        end
        ST_REG: begin
          if (fault_i) begin
            state   <= ST_FAULT;
            pgood_o <= 1'b0;
          end else if (slew_tick) begin
            code_o <= step_toward(code_o, req);
          end
        end
        default: pgood_o <= 1'b0;
      endcase
    end
  end

  assign phase_en_o = (in_ss || in_reg) ? mask : '0;
  assign psave_o    = in_reg && !psi_lat_n;
  assign par_mode_o = par;
  assign nb_hiz_o   = par;
  assign nb_en_o    = !par && pgood_o && pwrok_i;
  assign sv_clk_o   = vid_i[2];
  assign sv_dat_o   = vid_i[3];
endmodule

// File: rtl/vr_boot_seq_chk.sv
module vr_boot_seq_chk
  import vr_boot_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              fault_i,
  input logic [CODE_W-1:0] code_o,
  input logic [PH_N-1:0]   phase_en_o,
  input logic              pgood_o,
  input logic              psave_o,
  input logic              par_mode_o,
  input logic              nb_en_o,
  input logic              nb_hiz_o,
  input logic              in_ss,
  input logic              ss_tick
);
  // R5: one step per clock at most
  a_r5_code_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i) |-> (code_o == $past(code_o) || code_o == $past(code_o) + 6'd1 ||
                     code_o == $past(code_o) - 6'd1));
  // R4: soft-start moves only on its pacing tick
  a_r4_ss_paced: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ss && $past(in_ss) && !$past(ss_tick)) |-> $stable(code_o));
  // R5: power-good held while enabled and fault free
  a_r5_pgood_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood_o && en_i && !fault_i) |=> pgood_o);
  // R8: disable clears outputs
  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (code_o == '0 && !pgood_o && phase_en_o == '0 && !psave_o));
  // R9: fault shuts phases and power-good
  a_r9_fault_safe: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && fault_i) |=> (!pgood_o && phase_en_o == '0));
  // R2: northbridge held off in parallel mode
  a_r2_par_nb_off: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode_o |-> (nb_hiz_o && !nb_en_o));
  // R7: power-save only once soft-start is done
  a_r7_psave_after_ss: assert property (@(posedge clk) disable iff (!rst_n)
    psave_o |-> pgood_o);
  // R6: power-good implies phases running
  a_r6_phases_when_good: assert property (@(posedge clk) disable iff (!rst_n)
    pgood_o |-> (phase_en_o != '0));
endmodule

bind vr_boot_seq vr_boot_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .fault_i(fault_i), .code_o(code_o),
  .phase_en_o(phase_en_o), .pgood_o(pgood_o), .psave_o(psave_o),
  .par_mode_o(par_mode_o), .nb_en_o(nb_en_o), .nb_hiz_o(nb_hiz_o),
  .in_ss(in_ss), .ss_tick(ss_tick)
);

// File: tb/vr_boot_seq_tb.sv
module vr_boot_seq_tb;
  localparam int SS_DIV   = 8;
  localparam int SLEW_DIV = 2;
  localparam int NV       = 7;
  // {par, vid[5:0], g4, g2, boot[5:0], mask[3:0]}
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 6'b100110, 1'b1, 1'b1, 6'd38, 4'b1111},
    {1'b1, 6'b000011, 1'b0, 1'b1, 6'd3,  4'b0111},
    {1'b0, 6'b001000, 1'b0, 1'b0, 6'd40, 4'b0011},
    {1'b0, 6'b000100, 1'b1, 1'b1, 6'd36, 4'b1111},
    {1'b0, 6'b000000, 1'b1, 1'b0, 6'd44, 4'b1111},
    {1'b0, 6'b001100, 1'b0, 1'b1, 6'd32, 4'b0111},
    {1'b1, 6'b111111, 1'b1, 1'b1, 6'd63, 4'b1111}
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, psi_n = 1'b1, g4 = 1'b1, g2 = 1'b1;
  logic pwrok = 1'b1, fault = 1'b0;
  logic [5:0] vid = '0;
  logic [5:0] code;
  logic nb_en, nb_hiz, pgood, psave, par_mode, sv_clk, sv_dat;
  logic [3:0] ph;
  int n_chk = 0, n_fail = 0;
  logic mon_on = 1'b0, mon_bad = 1'b0;

  always #4 clk = ~clk;

  vr_boot_seq #(.SS_DIV(SS_DIV), .SLEW_DIV(SLEW_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .vid_i(vid), .psi_n_i(psi_n),
    .strap_g4_i(g4), .strap_g2_i(g2), .pwrok_i(pwrok), .fault_i(fault),
    .code_o(code), .nb_en_o(nb_en), .nb_hiz_o(nb_hiz), .phase_en_o(ph),
    .pgood_o(pgood), .psave_o(psave), .par_mode_o(par_mode),
    .sv_clk_o(sv_clk), .sv_dat_o(sv_dat)
  );

  always @(negedge clk) if (mon_on && !pgood) mon_bad <= 1'b1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input logic [5:0] v, input logic s4, input logic s2, input logic p);
    @(negedge clk);
    vid = v; g4 = s4; g2 = s2; psi_n = p;
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic stop();
    @(negedge clk);
    en = 1'b0;
    cyc(2);
  endtask

  initial begin
    cyc(150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R10 reset state
    chk("R10 code", int'(code), 0);
    chk("R10 pgood", int'(pgood), 0);
    chk("R10 phases", int'(ph), 0);
    chk("R10 psave", int'(psave), 0);

    // Table walk: R1 R2 R3 R4 R6 R8
    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      start(v[17:12], v[11], v[10], 1'b1);
      cyc(int'(v[9:4]) * SS_DIV + 20);
      chk("R1 mode", int'(par_mode), int'(v[18]));
      chk("R4 boot code", int'(code), int'(v[9:4]));
      chk("R4 pgood", int'(pgood), 1);
      chk("R6 phases", int'(ph), int'(v[3:0]));
      chk("R2 R3 nb_hiz", int'(nb_hiz), int'(v[18]));
      chk("R3 nb_en", int'(nb_en), int'(!v[18]));
      stop();
      chk("R8 code cleared", int'(code), 0);
      chk("R8 pgood cleared", int'(pgood), 0);
      chk("R8 phases cleared", int'(ph), 0);
    end

    // R4 R7: mid ramp and power-save delay; R6 straps ignored after edge
    start(6'd38, 1'b1, 1'b1, 1'b0);
    cyc(2);
    psi_n = 1'b1; g4 = 1'b0; g2 = 1'b0;
    cyc(100);
    chk("R4 no pgood mid ramp", int'(pgood), 0);
    chk("R4 code mid ramp", int'(code > 0 && code < 38), 1);
    chk("R7 psave held in soft-start", int'(psave), 0);
    cyc(38 * SS_DIV);
    chk("R7 psave after soft-start", int'(psave), 1);
    chk("R6 straps ignored", int'(ph), 4'b1111);
    // R2 pwrok ignored in parallel mode
    pwrok = 1'b0;
    cyc(2);
    chk("R2 pwrok ignored pgood", int'(pgood), 1);
    chk("R2 nb_en off", int'(nb_en), 0);
    pwrok = 1'b1;
    // R5 follow down and up with pgood held
    mon_on = 1'b1; mon_bad = 1'b0;
    vid = 6'd20;
    cyc(18 * SLEW_DIV + 10);
    chk("R5 follow down", int'(code), 20);
    vid = 6'd50;
    cyc(30 * SLEW_DIV + 10);
    chk("R5 follow up", int'(code), 50);
    mon_on = 1'b0;
    chk("R5 pgood held through changes", int'(mon_bad), 0);
    stop();
    chk("R8 psave cleared", int'(psave), 0);

    // R4 boot latched; later vid ignored during soft-start
    start(6'b001010, 1'b1, 1'b1, 1'b1);
    cyc(1);
    vid = 6'd30;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (pgood) break;
    end
    chk("R4 pgood at latched boot", int'(code), 10);
    cyc(20 * SLEW_DIV + 10);
    chk("R2 live request after pgood", int'(code), 30);
    stop();

    // R3 serial: ignored lines, pass-through, pwrok gating
    start(6'b000000, 1'b1, 1'b1, 1'b1);
    cyc(44 * SS_DIV + 20);
    vid = 6'b110011;
    cyc(20);
    chk("R3 other lines ignored", int'(code), 44);
    vid = 6'b000100;
    cyc(1);
    chk("R3 sv_clk pass", int'(sv_clk), 1);
    chk("R3 sv_dat pass", int'(sv_dat), 0);
    vid = 6'b001000;
    cyc(1);
    chk("R3 sv_dat pass high", int'(sv_dat), 1);
    pwrok = 1'b0;
    cyc(1);
    chk("R3 nb_en follows pwrok", int'(nb_en), 0);
    pwrok = 1'b1;
    cyc(1);
    chk("R3 nb_en with pwrok", int'(nb_en), 1);

    // R9 fault handling
    fault = 1'b1;
    cyc(1);
    chk("R9 pgood on fault", int'(pgood), 0);
    chk("R9 phases on fault", int'(ph), 0);
    fault = 1'b0;
    cyc(50);
    chk("R9 held after fault clears", int'(pgood), 0);
    chk("R9 phases held", int'(ph), 0);
    stop();
    start(6'b000000, 1'b1, 1'b1, 1'b1);
    cyc(44 * SS_DIV + 20);
    chk("R9 recovers after toggle", int'(pgood), 1);
    stop();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule